// File: doc/BRIEF.md
# Receive Frame Validator and Address Filter

This block sits behind the line decoder on the receive side of a 10 Mb/s Ethernet MAC. It receives one NRZ byte per strobe while carrier is present. A state machine waits for carrier, hunts through the preamble for the start-of-frame delimiter, and then treats every following byte as frame data. Frame data runs from the first destination-address byte to the last FCS byte.

While frame bytes arrive, three helpers run in parallel. The first compares the destination address with the programmed station address, or with the all-ones broadcast address when that is enabled. The second counts the length. The third runs a reflected CRC-32 over every frame byte. Each byte is passed on with a write enable for as long as the destination address can still match, so a buffer can store it at once. When carrier drops, the block gives one status word: accept, runt, oversize, CRC error and final length.

The machine has five states. IDLE waits for carrier (carrier high goes to HUNT). HUNT scans bytes: 0x55 stays in HUNT, 0xD5 after at least one 0x55 goes to DATA, any other byte goes to SKIP, and carrier low goes to IDLE. SKIP ignores the rest of the carrier event (carrier low goes to IDLE). DATA consumes frame bytes (carrier low goes to REPORT). REPORT lasts one cycle: it returns to HUNT if carrier is already back, otherwise to IDLE.

Top module: `rx_frame_filter`

## Requirements
- R1: During and directly after reset, wr_en, stat_vld and stat_accept are 0.
- R2: No byte before the delimiter is written. 0xD5 is recognised only after at least one 0x55 in the same carrier event. Any other byte in the hunt, or 0xD5 with no 0x55 before it, discards the carrier event, and no status is reported for it.
- R3: The first frame byte is compared with station_addr[47:40] and the sixth with station_addr[7:0]. wr_en is high with each accepted frame byte while every address byte seen so far matches. wr_byte equals rx_byte in that cycle.
- R4: From the first destination byte that matches neither the station address nor an enabled broadcast, wr_en stays low for the rest of the frame, and stat_accept is 0.
- R5: A destination of FF:FF:FF:FF:FF:FF is written and accepted when bcast_en is 1. It is rejected when bcast_en is 0, unless it equals the station address.
- R6: stat_len is the number of frame bytes accepted (rx_byte_vld and carrier both high), from the first destination byte through the last FCS byte.
- R7: stat_runt is 1 exactly when stat_len < 64.
- R8: stat_oversize is 1 exactly when stat_len > 1518.
- R9: stat_crc_err is 1 exactly when the reflected CRC-32 (polynomial 0x04C11DB7, initial value all ones) over all frame bytes, FCS included, does not leave the residue 0xC704DD7B in normal bit order. An FCS sent least significant byte first as the inverted CRC passes.
- R10: stat_accept = address match AND NOT runt AND NOT oversize AND NOT CRC error.
- R11: stat_vld is a one-cycle pulse in the cycle after the first clock edge at which carrier is sampled low during frame data. A byte strobed while carrier is low is not counted.
- R12: A new frame may begin in the cycle of the status pulse. Length, CRC and address state restart at its delimiter, so each frame gets its own status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte | input | 8 | Decoded receive byte |
| rx_byte_vld | input | 1 | Strobe: rx_byte is valid this cycle |
| carrier | input | 1 | Carrier present |
| station_addr | input | 48 | Individual address; bits 47:40 are the first byte on the wire |
| bcast_en | input | 1 | Accept the all-ones destination |
| wr_en | output | 1 | Write the current byte to the buffer |
| wr_byte | output | 8 | Byte to write |
| stat_vld | output | 1 | End-of-frame status pulse |
| stat_accept | output | 1 | Frame accepted |
| stat_runt | output | 1 | Frame shorter than 64 bytes |
| stat_oversize | output | 1 | Frame longer than 1518 bytes |
| stat_crc_err | output | 1 | FCS check failed |
| stat_len | output | LEN_W | Frame length in bytes |

## Verification
The status pulse of one frame and the restart of the hunt for the next frame can fall in the same cycle. The bench provokes this by dropping carrier for exactly one cycle between two frames, and by strobing a byte in the drop cycle itself. It then judges that two separate status pulses appear, and that each carries its own frame's length with the stray byte left out. A second overlap has runt and CRC error raised together on one short, corrupted frame; both flags must be set and accept must be clear.

// File: rtl/rxf_pkg.sv
`timescale 1ns/1ps
package rxf_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HUNT,
        S_SKIP,
        S_DATA,
        S_REPORT
    } rxf_state_e;

    localparam logic [7:0]  PRE_BYTE   = 8'h55;
    localparam logic [7:0]  SFD_BYTE   = 8'hD5;
    localparam int          DA_BYTES   = 6;
    localparam logic [31:0] CRC_INIT   = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_POLY_R = 32'hEDB8_8320;
    localparam logic [31:0] CRC_RESID  = 32'hC704_DD7B;

    // Bit-serial reflected update, least significant data bit first.
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = r[0] ^ d[i];
            r  = r >> 1;
            if (fb) r = r ^ CRC_POLY_R;
        end
        return r;
    endfunction

endpackage

// File: rtl/rxf_crc32.sv
`timescale 1ns/1ps
module rxf_crc32
    import rxf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       step,
    input  logic [7:0] din,
    output logic       crc_ok
);
    logic [31:0] crc_q;
    logic [31:0] crc_rev;

    always_ff @(posedge clk) begin
        if (!rst_n)    crc_q <= CRC_INIT;
        else if (clr)  crc_q <= CRC_INIT;
        else if (step) crc_q <= crc_step(crc_q, din);
    end

    always_comb begin
        for (int i = 0; i < 32; i++) crc_rev[i] = crc_q[31-i];
    end

    assign crc_ok = (crc_rev == CRC_RESID);
endmodule

// File: rtl/rxf_len_count.sv
`timescale 1ns/1ps
module rxf_len_count #(
    parameter int LEN_W   = 12,
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1518
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    output logic [LEN_W-1:0] len,
    output logic             runt,
    output logic             oversize
);
    localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_LEN);

    always_ff @(posedge clk) begin
        if (!rst_n)                  len <= '0;
        else if (clr)                len <= '0;
        else if (step && len != '1)  len <= len + 1'b1;
    end

    assign runt     = (len < LEN_MIN);
    assign oversize = (len > LEN_MAX);
endmodule

// File: rtl/rxf_da_filter.sv
`timescale 1ns/1ps
module rxf_da_filter
    import rxf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        step,
    input  logic [7:0]  din,
    input  logic [47:0] station,
    input  logic        bcast_en,
    output logic        pass_now,
    output logic        hit
);
    localparam logic [2:0] DA_LAST = 3'(DA_BYTES);

    logic [7:0] stn_b [DA_BYTES];
    logic [7:0] stn_byte;
    logic [2:0] idx;
    logic       ucast_ok, bc_ok;
    logic       in_da, u_next, b_next;

    for (genvar g = 0; g < DA_BYTES; g++) begin : g_stn
        assign stn_b[g] = station[47-8*g -: 8];
    end

    always_comb begin
        stn_byte = '0;
        for (int k = 0; k < DA_BYTES; k++)
            if (idx == 3'(k)) stn_byte = stn_b[k];
    end

    assign in_da    = (idx < DA_LAST);
    assign u_next   = ucast_ok & (!in_da | (din == stn_byte));
    assign b_next   = bc_ok    & (!in_da | (din == 8'hFF));
    assign pass_now = u_next | (bcast_en & b_next);
    assign hit      = (idx == DA_LAST) & (ucast_ok | (bcast_en & bc_ok));

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            idx      <= '0;
            ucast_ok <= 1'b1;
            bc_ok    <= 1'b1;
        end else if (step) begin
            ucast_ok <= u_next;
            bc_ok    <= b_next;
            if (in_da) idx <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/rx_frame_filter.sv
`timescale 1ns/1ps
module rx_frame_filter
    import rxf_pkg::*;
#(
    parameter int LEN_W   = 12,
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1518
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       rx_byte,
    input  logic             rx_byte_vld,
    input  logic             carrier,
    input  logic [47:0]      station_addr,
    input  logic             bcast_en,
    output logic             wr_en,
    output logic [7:0]       wr_byte,
    output logic             stat_vld,
    output logic             stat_accept,
    output logic             stat_runt,
    output logic             stat_oversize,
    output logic             stat_crc_err,
    output logic [LEN_W-1:0] stat_len
);
    rxf_state_e state_q, state_d;
    logic       pre_seen_q;
    logic       take, sfd_hit, frm_clr, frm_step;
    logic       pass_now, addr_hit, crc_ok, runt, oversize;
    logic [LEN_W-1:0] len;

    assign take     = rx_byte_vld & carrier;
    assign sfd_hit  = (state_q == S_HUNT) & take & pre_seen_q & (rx_byte == SFD_BYTE);
    assign frm_clr  = sfd_hit;
    assign frm_step = (state_q == S_DATA) & take;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (carrier) state_d = S_HUNT;
            S_HUNT: begin
                if (!carrier)                                     state_d = S_IDLE;
                else if (sfd_hit)                                 state_d = S_DATA;
                else if (rx_byte_vld && rx_byte != PRE_BYTE)      state_d = S_SKIP;
            end
            S_SKIP:   if (!carrier) state_d = S_IDLE;
            S_DATA:   if (!carrier) state_d = S_REPORT;
            S_REPORT: state_d = carrier ? S_HUNT : S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            pre_seen_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            pre_seen_q <= (state_q == S_HUNT) & (pre_seen_q | (take & rx_byte == PRE_BYTE));
        end
    end

    always_comb begin
        wr_en         = frm_step & pass_now;
        wr_byte       = rx_byte;
        stat_vld      = (state_q == S_REPORT);
        stat_runt     = stat_vld & runt;
        stat_oversize = stat_vld & oversize;
        stat_crc_err  = stat_vld & !crc_ok;
        stat_accept   = stat_vld & addr_hit & !runt & !oversize & crc_ok;
        stat_len      = stat_vld ? len : '0;
    end

    rxf_da_filter u_da (
        .clk(clk), .rst_n(rst_n), .clr(frm_clr), .step(frm_step), .din(rx_byte),
        .station(station_addr), .bcast_en(bcast_en), .pass_now(pass_now), .hit(addr_hit)
    );

    rxf_len_count #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_len (
        .clk(clk), .rst_n(rst_n), .clr(frm_clr), .step(frm_step),
        .len(len), .runt(runt), .oversize(oversize)
    );

    rxf_crc32 u_crc (
        .clk(clk), .rst_n(rst_n), .clr(frm_clr), .step(frm_step), .din(rx_byte), .crc_ok(crc_ok)
    );
endmodule

// File: rtl/rxf_checker.sv
`timescale 1ns/1ps
module rxf_checker (
    input logic clk,
    input logic rst_n,
    input logic carrier,
    input logic rx_byte_vld,
    input logic wr_en,
    input logic stat_vld,
    input logic stat_accept,
    input logic stat_runt,
    input logic stat_oversize,
    input logic stat_crc_err
);
    assert_wr_needs_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (rx_byte_vld && carrier));

    assert_stat_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stat_vld |=> !stat_vld);

    assert_stat_after_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stat_vld |-> !$past(carrier));

    assert_accept_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_vld && stat_accept) |-> !(stat_runt || stat_oversize || stat_crc_err));

    assert_len_flags_apart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_vld |-> !(stat_runt && stat_oversize));

    assert_no_write_in_report_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stat_vld |-> !wr_en);
endmodule

bind rx_frame_filter rxf_checker u_rxf_checker (
    .clk(clk), .rst_n(rst_n), .carrier(carrier), .rx_byte_vld(rx_byte_vld),
    .wr_en(wr_en), .stat_vld(stat_vld), .stat_accept(stat_accept),
    .stat_runt(stat_runt), .stat_oversize(stat_oversize), .stat_crc_err(stat_crc_err)
);

// File: tb/test_rx_frame_filter.sv
`timescale 1ns/1ps
module test_rx_frame_filter;
    localparam int LEN_W = 12;
    localparam logic [47:0] STN = 48'h021A_2B3C_4D5E;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [7:0]       rx_byte = '0;
    logic             rx_byte_vld = 1'b0;
    logic             carrier = 1'b0;
    logic             bcast_en = 1'b0;
    logic             wr_en, wr_byte_dummy;
    logic [7:0]       wr_byte;
    logic             stat_vld, stat_accept, stat_runt, stat_oversize, stat_crc_err;
    logic [LEN_W-1:0] stat_len;

    int checks = 0;
    int failures = 0;
    int stat_cnt = 0;
    int wr_cnt = 0;
    int byte_err = 0;
    logic [LEN_W-1:0] len_log [4];
    logic acc_q, runt_q, over_q, crc_q;
    logic [7:0] fb [1600];

    assign wr_byte_dummy = 1'b0;

    always #5 clk = ~clk;

    rx_frame_filter #(.LEN_W(LEN_W)) i_rx_frame_filter (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_byte_vld(rx_byte_vld),
        .carrier(carrier), .station_addr(STN), .bcast_en(bcast_en),
        .wr_en(wr_en), .wr_byte(wr_byte), .stat_vld(stat_vld), .stat_accept(stat_accept),
        .stat_runt(stat_runt), .stat_oversize(stat_oversize), .stat_crc_err(stat_crc_err),
        .stat_len(stat_len)
    );

    always @(negedge clk) begin
        if (wr_en) begin
            wr_cnt++;
            if (wr_byte != rx_byte) byte_err++;
        end
        if (stat_vld) begin
            if (stat_cnt < 4) len_log[stat_cnt] = stat_len;
            acc_q = stat_accept; runt_q = stat_runt; over_q = stat_oversize; crc_q = stat_crc_err;
            stat_cnt++;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic v, input logic [7:0] b);
        carrier = c; rx_byte_vld = v; rx_byte = b;
        @(posedge clk); #1;
    endtask

    function automatic logic [31:0] fcs_of(input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            c = c ^ {24'h0, fb[i]};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        return ~c;
    endfunction

    // kind: 0 station, 1 broadcast, 2 station with first byte altered
    task automatic build(input int len, input int kind, input bit bad);
        logic [31:0] f;
        for (int i = 0; i < 6; i++) begin
            fb[i] = (kind == 1) ? 8'hFF : STN[47-8*i -: 8];
        end
        if (kind == 2) fb[0] = fb[0] ^ 8'h01;
        for (int i = 6; i < len - 4; i++) fb[i] = 8'(i) ^ 8'h3C;
        f = fcs_of(len - 4);
        for (int i = 0; i < 4; i++) fb[len-4+i] = f[8*i +: 8];
        if (bad) fb[len-1] = fb[len-1] ^ 8'h10;
    endtask

    task automatic send(input int len, input bit vld_on_drop);
        for (int i = 0; i < 7; i++) drive(1'b1, 1'b1, 8'h55);
        drive(1'b1, 1'b1, 8'hD5);
        for (int i = 0; i < len; i++) drive(1'b1, 1'b1, fb[i]);
        drive(1'b0, vld_on_drop, 8'hA5);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 8'h00);
    endtask

    task automatic clear_mon();
        stat_cnt = 0; wr_cnt = 0; byte_err = 0;
    endtask

    typedef struct packed {
        logic [11:0] len;
        logic [1:0]  kind;
        logic        be;
        logic        bad;
        logic        acc;
        logic        runt;
        logic        over;
        logic        crc;
        logic [11:0] wrs;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{12'd64,   2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 12'd64},
        '{12'd63,   2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 12'd63},
        '{12'd1518, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 12'd1518},
        '{12'd1519, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 12'd1519},
        '{12'd100,  2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 12'd100},
        '{12'd100,  2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'd0},
        '{12'd100,  2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'd0},
        '{12'd80,   2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 12'd80},
        '{12'd60,   2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 12'd60}
    };

    initial begin
        #1_950_000;
        failures++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(posedge clk); #1;
        idle(3);
        check("R1", "wr_en in reset", int'(wr_en), 0);
        check("R1", "stat_vld in reset", int'(stat_vld), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "stat_vld after reset", int'(stat_vld), 0);
        check("R1", "stat_accept after reset", int'(stat_accept), 0);
        @(posedge clk); #1;

        // Table walk: R3 R4 R5 R6 R7 R8 R9 R10
        for (int v = 0; v < 9; v++) begin
            bcast_en = VECS[v].be;
            build(int'(VECS[v].len), int'(VECS[v].kind), VECS[v].bad);
            clear_mon();
            send(int'(VECS[v].len), 1'b0);
            idle(3);
            check("R11", $sformatf("vec%0d status count", v), stat_cnt, 1);
            check("R6", $sformatf("vec%0d length", v), int'(len_log[0]), int'(VECS[v].len));
            check("R7", $sformatf("vec%0d runt", v), int'(runt_q), int'(VECS[v].runt));
            check("R8", $sformatf("vec%0d oversize", v), int'(over_q), int'(VECS[v].over));
            check("R9", $sformatf("vec%0d crc error", v), int'(crc_q), int'(VECS[v].crc));
            check("R10", $sformatf("vec%0d accept", v), int'(acc_q), int'(VECS[v].acc));
            check("R4", $sformatf("vec%0d write count (R3 R5)", v), wr_cnt, int'(VECS[v].wrs));
            check("R3", $sformatf("vec%0d wr_byte mismatches", v), byte_err, 0);
        end
        bcast_en = 1'b0;

        // R2: foreign byte in the preamble discards the event
        build(70, 0, 1'b0);
        clear_mon();
        drive(1'b1, 1'b1, 8'h55); drive(1'b1, 1'b1, 8'h55); drive(1'b1, 1'b1, 8'h55);
        drive(1'b1, 1'b1, 8'h12); drive(1'b1, 1'b1, 8'hD5);
        for (int i = 0; i < 70; i++) drive(1'b1, 1'b1, fb[i]);
        idle(4);
        check("R2", "status after bad preamble", stat_cnt, 0);
        check("R2", "writes after bad preamble", wr_cnt, 0);

        // R2: delimiter with no preceding 0x55 in the hunt
        clear_mon();
        drive(1'b1, 1'b1, 8'h55); drive(1'b1, 1'b1, 8'hD5);
        for (int i = 0; i < 70; i++) drive(1'b1, 1'b1, fb[i]);
        idle(4);
        check("R2", "status after bare delimiter", stat_cnt, 0);
        check("R2", "writes after bare delimiter", wr_cnt, 0);

        // R12 + R11: one-cycle gap, stray byte in the drop cycle
        clear_mon();
        build(70, 0, 1'b0);
        send(70, 1'b1);
        build(64, 0, 1'b0);
        send(64, 1'b0);
        idle(3);
        check("R12", "status count back-to-back", stat_cnt, 2);
        check("R11", "first length ignores drop-cycle byte", int'(len_log[0]), 70);
        check("R12", "second length restarted", int'(len_log[1]), 64);
        check("R12", "second frame accepted", int'(acc_q), 1);
        check("R12", "writes across both frames", wr_cnt, 134);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule